// File: doc/BRIEF.md
# Branch-Aware Program Counter Unit

This block holds the fetch address of a processor whose instructions are all four bytes wide. On every cycle that is not stalled it moves to the next instruction. When the pipeline reports a taken branch, it instead jumps to a target formed from a signed 16-bit displacement. The displacement counts whole instructions, not bytes, and is added to the address that has already been incremented. As a result, a displacement of zero simply falls through, and minus one lands back on the branch.

The unit exposes the current address and its sequential successor. The successor is the link value that a decode or writeback stage may need. A stall freezes the address, and a branch strobe raised during a stalled cycle is discarded. The condition of the branch is evaluated elsewhere, as is instruction fetch. All address arithmetic wraps modulo 2^32, and no fault is raised.

Top module: `branch_pc_unit`

## Requirements
- R1: While `rst_n` is low the PC equals the parameter `RESET_VEC` with its two low bits forced to zero (default 0x0000_1000), and it still holds that value when reset is released.
- R2: Bits [1:0] of `pc_o` are zero in every cycle.
- R3: On a clock edge with `stall_i` low and `br_taken_i` low, the PC becomes the old PC plus 4.
- R4: On a clock edge with `stall_i` low and `br_taken_i` high, the PC becomes old PC + 4 + (sign-extended `br_offset_i` × 4).
- R5: A taken branch with offset 0x0000 gives the same next PC as sequential flow.
- R6: A taken branch with offset 0xFFFF (−1) returns to the branch's own address. Offset 0xFFFE (−2) goes to the instruction before it.
- R7: Offset 0xFFFB (−5) moves the PC to old PC + 4 − 20.
- R8: On a clock edge with `stall_i` high, the PC keeps its value whatever `br_taken_i` and `br_offset_i` are.
- R9: Sums that pass 0xFFFF_FFFF or fall below 0 wrap modulo 2^32.
- R10: `pc_plus4_o` always equals `pc_o` + 4 modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze the PC this cycle |
| br_taken_i | input | 1 | Taken-branch strobe |
| br_offset_i | input | 16 | Signed displacement in instructions |
| pc_o | output | 32 | Current PC |
| pc_plus4_o | output | 32 | Sequential successor of the current PC |

## Verification
The embedded assertions check the following on every cycle:
- the next-address relation for sequential flow, taken branches and stalls;
- word alignment;
- the link output;
- the value loaded when reset is released.

Some cases can only be shown by the bench's scenarios:
- the named corner offsets: zero, −1, −2 and −5;
- wrap-around in both directions through chosen extreme displacements;
- a branch strobe being dropped while stalled.

A seeded random mix of stalls, branches and offsets is compared with an independent reference model.

// File: rtl/pc_pkg.sv
package pc_pkg;
  // Instructions are 2**INSTR_LOG2 bytes wide.
  localparam int unsigned INSTR_LOG2 = 2;

  typedef enum logic [1:0] {
    PC_SEL_HOLD   = 2'd0,
    PC_SEL_SEQ    = 2'd1,
    PC_SEL_BRANCH = 2'd2
  } pc_sel_e;
endpackage

// File: rtl/pc_offset_scaler.sv
module pc_offset_scaler #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned SHIFT   = 2
) (
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] scaled_o
);
  localparam int unsigned EXT_W = OFF_W + SHIFT;

  logic [EXT_W-1:0] shifted;
  assign shifted = {offset_i, {SHIFT{1'b0}}};

  generate
    if (ADDR_W > EXT_W) begin : g_extend
      assign scaled_o = {{(ADDR_W-EXT_W){offset_i[OFF_W-1]}}, shifted};
    end else begin : g_trunc
      assign scaled_o = shifted[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] scaled_i,
  input  logic              stall_i,
  input  logic              taken_i,
  output logic [ADDR_W-1:0] pc_inc_o,
  output logic [ADDR_W-1:0] pc_next_o,
  output logic              load_o,
  output pc_sel_e           sel_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << SHIFT;

  logic [ADDR_W-1:0] target;

  assign pc_inc_o = pc_i + STEP;
  assign target   = pc_inc_o + scaled_i;

  always_comb begin
    if (stall_i)      sel_o = PC_SEL_HOLD;
    else if (taken_i) sel_o = PC_SEL_BRANCH;
    else              sel_o = PC_SEL_SEQ;
  end

  always_comb begin
    unique case (sel_o)
      PC_SEL_BRANCH: pc_next_o = target;
      PC_SEL_SEQ:    pc_next_o = pc_inc_o;
      default:       pc_next_o = pc_i;
    endcase
  end

  assign load_o = (sel_o != PC_SEL_HOLD);
endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       SHIFT     = 2,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << SHIFT) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] RESET_ALN  = RESET_VEC & ALIGN_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= RESET_ALN;
    else if (load_i) q_o <= d_i & ALIGN_MASK;
  end

  // R1: value seen on the edge that first samples reset released
  assert_reset_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q_o == RESET_ALN);

  // R2: low bits never set
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o & ~ALIGN_MASK) == '0);
endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import pc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFF_W     = 16,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              br_taken_i,
  input  logic [OFF_W-1:0]  br_offset_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] pc_plus4_o
);
  localparam int unsigned       SHIFT = INSTR_LOG2;
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(1) << SHIFT;

  logic [ADDR_W-1:0] scaled;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] pc_next;
  logic              load;
  pc_sel_e           sel;

  pc_offset_scaler #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_scaler (
    .offset_i (br_offset_i),
    .scaled_o (scaled)
  );

  pc_next_sel #(.ADDR_W(ADDR_W), .SHIFT(SHIFT)) u_next (
    .pc_i      (pc_q),
    .scaled_i  (scaled),
    .stall_i   (stall_i),
    .taken_i   (br_taken_i),
    .pc_inc_o  (pc_inc),
    .pc_next_o (pc_next),
    .load_o    (load),
    .sel_o     (sel)
  );

  pc_state_reg #(.ADDR_W(ADDR_W), .SHIFT(SHIFT), .RESET_VEC(ADDR_W'(RESET_VEC))) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .d_i    (pc_next),
    .q_o    (pc_q)
  );

  assign pc_o       = pc_q;
  assign pc_plus4_o = pc_inc;

  // R3, R9: sequential step, modulo width
  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !br_taken_i) |=> pc_o == $past(pc_o) + STEP);

  // R4, R9: branch target relative to incremented PC
  assert_branch_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && br_taken_i) |=>
      pc_o == $past(pc_o) + STEP +
              {{(ADDR_W-OFF_W-SHIFT){$past(br_offset_i[OFF_W-1])}}, $past(br_offset_i), {SHIFT{1'b0}}});

  // R8: stall freezes the PC regardless of the strobe
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(pc_o));

  // R10: link output tracks the register
  assert_link_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_plus4_o - pc_o == STEP);
endmodule

// File: tb/branch_pc_unit_bench.sv
module branch_pc_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        br = 1'b0;
  logic [15:0] off = 16'h0;
  logic [31:0] pc_o, pc_plus4_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_pc_unit u_branch_pc_unit (
    .clk(clk), .rst_n(rst_n), .stall_i(stall), .br_taken_i(br),
    .br_offset_i(off), .pc_o(pc_o), .pc_plus4_o(pc_plus4_o)
  );

  function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic s,
                                           input logic b, input logic [15:0] o);
    logic signed [31:0] disp;
    disp = 32'(signed'(o)) * 4;
    if (s) return pc;
    if (b) return pc + 32'd4 + disp;
    return pc + 32'd4;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic s, input logic b, input logic [15:0] o);
    stall = s; br = b; off = o;
    @(posedge clk);
    model_pc = ref_next(model_pc, s, b, o);
    @(negedge clk);
    check(tag, pc_o, model_pc);
    check("R10", pc_plus4_o, model_pc + 32'd4);
    check("R2", {30'd0, pc_o[1:0]}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] br_pc;
    repeat (3) @(negedge clk);
    check("R1 in reset", pc_o, RV);
    rst_n = 1'b1;
    model_pc = RV;
    check("R1 after release", pc_o, RV);

    step("R3 seq", 0, 0, 16'h0);
    step("R3 seq", 0, 0, 16'h1234);
    step("R5 zero offset", 0, 1, 16'h0000);
    br_pc = model_pc;
    step("R6 minus one", 0, 1, 16'hFFFF);
    check("R6 self loop", pc_o, br_pc);
    step("R6 minus one again", 0, 1, 16'hFFFF);
    step("R6 minus two", 0, 1, 16'hFFFE);
    check("R6 previous instr", pc_o, br_pc - 32'd4);
    br_pc = model_pc;
    step("R7 0xFFFB", 0, 1, 16'hFFFB);
    check("R7 minus 5", pc_o, br_pc + 32'd4 - 32'd20);
    step("R4 forward", 0, 1, 16'h0010);
    br_pc = model_pc;
    step("R8 stall with strobe", 1, 1, 16'h0100);
    check("R8 held", pc_o, br_pc);
    step("R8 stall plain", 1, 0, 16'h0);
    check("R8 held", pc_o, br_pc);
    step("R3 after stall", 0, 0, 16'h0);
    // Wrap below zero, then wrap back above the top
    step("R9 wrap down", 0, 1, 16'h8000);
    step("R9 wrap up", 0, 1, 16'h7FFF);

    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3000; i++) begin
      logic s, b;
      logic [15:0] o;
      s = ($urandom % 5) == 0;
      b = ($urandom % 3) == 0;
      o = 16'($urandom);
      if (($urandom % 8) == 0) o = 16'hFFFF;
      step(b ? "R4 random branch" : (s ? "R8 random stall" : "R3 random seq"), s, b, o);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule